// File: doc/BRIEF.md
# Mode Register Bank with Deferred Update

This block holds the configuration of a four-channel light driver. It has thirteen byte registers at indices 0x0 to 0xC: two mode registers, four per-channel duty registers, a group duty register, a group rate register, an output-state register, three secondary-address registers and a broadcast-address register. A bus front end that has already decoded the serial framing accesses them one byte at a time. It presents an index, a write or read strobe for each acknowledged byte, and a one-cycle pulse when the transaction ends.

Every write lands in a shadow copy, and reads always return the shadow copy. A separate active copy drives the output ports. A timing bit in the second mode register decides when the active copy follows the shadow. With the bit at 0, the whole shadow is copied when the end-of-transaction pulse arrives. With the bit at 1, each byte is copied as it is written. The block also exports the sleep, broadcast-enable and secondary-address enable levels. After sleep is released it raises a wake-pending flag for a set number of cycles, which stands for the start-up time of the timing source.

Top module: `mode_reg_bank`

## Requirements
- R1: After reset the outputs are sleep=1, broadcast enable=1, secondary enables=000, group blink=0, invert=0, totem drive=1, update-on-ack=0, idle bits=00, and every duty/rate/state/address byte is 0x00. Index 0x0 reads {ptr_mode,5'b10001} and index 0x1 reads 0x04.
- R2: Bits 7:5 of index 0x0 always read the current `ptr_mode` input. Writes to those bits are ignored.
- R3: Bits 7:6 of index 0x1 always read 0, whatever value is written to them.
- R4: A write or read strobe to an index from 0x0 to 0xC raises `bus_ack` for one cycle on the next clock edge. Read data for that index appears in `bus_rdata` on the same edge.
- R5: A strobe to index 0xD, 0xE or 0xF is not acknowledged. It changes no register, no output and no `bus_rdata`.
- R6: While the shadow timing bit (index 0x1 bit 3) is 0, writes reach the shadow only and the outputs hold. On an `end_pulse` every shadow register is copied to the active copy at that clock edge.
- R7: While the shadow timing bit is 1, a written byte reaches its output at the same edge at which it enters the shadow.
- R8: The outputs map as follows. Index 0x0: bit4 sleep, bits 3:1 `sub_en[2:0]`, bit0 broadcast enable. Index 0x1: bit5 group blink, bit4 invert, bit3 update-on-ack, bit2 totem drive, bits 1:0 idle. Indices 0x2–0x5 map to `led_duty` lanes 0–3, 0x6 to group duty, 0x7 to group rate, 0x8 to output state, 0x9–0xB to `sub_addr` lanes 0–2, and 0xC to the broadcast address.
- R9: When the active sleep bit falls, `wake_pending` is high for exactly WAKE_CYCLES cycles starting at that edge. Setting sleep again clears it.
- R10: The timing decision for a byte uses the shadow timing bit as it stood before that byte. A write that sets the bit is itself deferred, and the next byte is applied at once.
- R11: A write in the same cycle as `end_pulse` is included in that cycle's copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one per acknowledged byte |
| bus_rd | input | 1 | Read strobe |
| end_pulse | input | 1 | One-cycle end-of-transaction pulse |
| ptr_mode | input | 3 | Current auto-increment mode, mirrored in index 0x0 |
| bus_ack | output | 1 | Access accepted (registered) |
| bus_rdata | output | 8 | Read byte (registered) |
| led_duty | output | 32 | Active per-channel duty bytes, lane k = channel k |
| grp_duty | output | 8 | Active group duty |
| grp_rate | output | 8 | Active group rate |
| led_state | output | 8 | Active output-state byte |
| sub_addr | output | 24 | Active secondary addresses, lane k = address k |
| bcast_addr | output | 8 | Active broadcast address |
| sleep | output | 1 | Active sleep level |
| sub_en | output | 3 | Active secondary-address enables |
| bcast_en | output | 1 | Active broadcast enable |
| grp_blink | output | 1 | Group mode: 0 dimming, 1 blinking |
| out_invert | output | 1 | Output inversion |
| upd_on_ack | output | 1 | Active copy of the timing bit |
| out_totem | output | 1 | Drive style: 1 push-pull, 0 open-drain |
| out_idle | output | 2 | Active idle-state bits |
| wake_pending | output | 1 | Start-up window after sleep release |

## Verification
The deferred path is tried with several writes and no end pulse, which separates shadow read-back from outputs that hold. The end pulse then releases them all at once, and a write placed in the pulse cycle shows whether that cycle's byte is kept or lost. The immediate path is entered by writing the timing bit itself, which shows whether the decision uses the old or the new bit value. Mirrored and reserved bits are written with all ones, and out-of-range indices are written and read, to show that nothing at the ports moves. The wake flag is counted edge by edge from the sleep release.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NREG     = 13;
  localparam int LAST_IDX = NREG - 1;

  localparam int IDX_MODE0 = 0;
  localparam int IDX_MODE1 = 1;
  localparam int IDX_DUTY0 = 2;
  localparam int N_LED     = 4;
  localparam int IDX_GDUTY = 6;
  localparam int IDX_GRATE = 7;
  localparam int IDX_STATE = 8;
  localparam int IDX_SUB0  = 9;
  localparam int N_SUB     = 3;
  localparam int IDX_BCAST = 12;

  localparam int BIT_SLEEP = 4;
  localparam int BIT_TIMING = 3;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NREG-1:0][DATA_W-1:0] bank_t;

  function automatic byte_t reset_value(input int idx);
    case (idx)
      IDX_MODE0: reset_value = 8'h11;
      IDX_MODE1: reset_value = 8'h04;
      default:   reset_value = 8'h00;
    endcase
  endfunction

  function automatic byte_t write_mask(input int idx);
    case (idx)
      IDX_MODE0: write_mask = 8'h1F;
      IDX_MODE1: write_mask = 8'h3F;
      default:   write_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/mrb_shadow.sv
module mrb_shadow
  import mrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic [2:0]        ptr_mode,
  output byte_t             rd_byte,
  output bank_t             shadow_q,
  output bank_t             shadow_d
);
  always_comb begin
    shadow_d = shadow_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && addr == ADDR_W'(i))
        shadow_d[i] = (shadow_q[i] & ~write_mask(i)) | (wdata & write_mask(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= reset_value(i);
    end else begin
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) begin
        rd_byte = shadow_q[i] & write_mask(i);
        if (i == IDX_MODE0) rd_byte[7:5] = ptr_mode;
      end
    end
  end
endmodule

// File: rtl/mrb_active.sv
module mrb_active
  import mrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bank_t             shadow_d,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              per_byte,
  input  logic              end_pulse,
  output bank_t             act_q,
  output logic              sleep_next
);
  bank_t act_d;

  always_comb begin
    act_d = act_q;
    if (end_pulse) begin
      act_d = shadow_d;
    end else if (wr_en && per_byte) begin
      for (int i = 0; i < NREG; i++)
        if (addr == ADDR_W'(i)) act_d[i] = shadow_d[i];
    end
  end

  assign sleep_next = act_d[IDX_MODE0][BIT_SLEEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) act_q[i] <= reset_value(i);
    end else begin
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/mrb_wake.sv
module mrb_wake #(
  parameter int WAKE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_now,
  input  logic sleep_next,
  output logic pending
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (sleep_now && !sleep_next) cnt <= CNT_W'(WAKE_CYCLES);
    else if (sleep_next)               cnt <= '0;
    else if (cnt != '0)                cnt <= cnt - 1'b1;
  end

  assign pending = (cnt != '0);
endmodule

// File: rtl/mode_reg_bank.sv
module mode_reg_bank
  import mrb_pkg::*;
#(
  parameter int WAKE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        end_pulse,
  input  logic [2:0]  ptr_mode,
  output logic        bus_ack,
  output logic [7:0]  bus_rdata,
  output logic [31:0] led_duty,
  output logic [7:0]  grp_duty,
  output logic [7:0]  grp_rate,
  output logic [7:0]  led_state,
  output logic [23:0] sub_addr,
  output logic [7:0]  bcast_addr,
  output logic        sleep,
  output logic [2:0]  sub_en,
  output logic        bcast_en,
  output logic        grp_blink,
  output logic        out_invert,
  output logic        upd_on_ack,
  output logic        out_totem,
  output logic [1:0]  out_idle,
  output logic        wake_pending
);
  logic  in_range, wr_ok, rd_ok, sleep_next;
  byte_t rd_byte;
  bank_t shadow_q, shadow_d, act_q;

  assign in_range = (bus_addr <= ADDR_W'(LAST_IDX));
  assign wr_ok    = bus_wr & in_range;
  assign rd_ok    = bus_rd & in_range;

  mrb_shadow u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .ptr_mode(ptr_mode), .rd_byte(rd_byte), .shadow_q(shadow_q), .shadow_d(shadow_d)
  );

  mrb_active u_active (
    .clk(clk), .rst(rst), .shadow_d(shadow_d), .wr_en(wr_ok), .addr(bus_addr),
    .per_byte(shadow_q[IDX_MODE1][BIT_TIMING]), .end_pulse(end_pulse),
    .act_q(act_q), .sleep_next(sleep_next)
  );

  mrb_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .sleep_now(act_q[IDX_MODE0][BIT_SLEEP]),
    .sleep_next(sleep_next), .pending(wake_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= wr_ok | rd_ok;
      if (rd_ok) bus_rdata <= rd_byte;
    end
  end

  generate
    for (genvar k = 0; k < N_LED; k++) begin : g_duty
      assign led_duty[k*DATA_W +: DATA_W] = act_q[IDX_DUTY0 + k];
    end
    for (genvar k = 0; k < N_SUB; k++) begin : g_sub
      assign sub_addr[k*DATA_W +: DATA_W] = act_q[IDX_SUB0 + k];
    end
  endgenerate

  assign grp_duty   = act_q[IDX_GDUTY];
  assign grp_rate   = act_q[IDX_GRATE];
  assign led_state  = act_q[IDX_STATE];
  assign bcast_addr = act_q[IDX_BCAST];
  assign sleep      = act_q[IDX_MODE0][4];
  assign sub_en     = act_q[IDX_MODE0][3:1];
  assign bcast_en   = act_q[IDX_MODE0][0];
  assign grp_blink  = act_q[IDX_MODE1][5];
  assign out_invert = act_q[IDX_MODE1][4];
  assign upd_on_ack = act_q[IDX_MODE1][3];
  assign out_totem  = act_q[IDX_MODE1][2];
  assign out_idle   = act_q[IDX_MODE1][1:0];
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        end_pulse,
  input logic [2:0]  ptr_mode,
  input logic        bus_ack,
  input logic [7:0]  bus_rdata,
  input logic [31:0] led_duty,
  input logic [7:0]  grp_rate,
  input logic        sleep,
  input logic        out_totem,
  input logic        wake_pending
);
  p_ack_valid_r4: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> ($past(bus_wr) || $past(bus_rd)) && $past(bus_addr) <= 4'hC);

  p_no_ack_range_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) && bus_addr > 4'hC |=> !bus_ack);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 4'h1 |=> bus_rdata[7:6] == 2'b00);

  p_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 4'h0 |=> bus_rdata[7:5] == $past(ptr_mode));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !end_pulse && !bus_wr |=> $stable({led_duty, grp_rate, sleep, out_totem}));

  p_wake_start_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> wake_pending);

  p_wake_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !wake_pending);
endmodule

bind mode_reg_bank mrb_checker u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .end_pulse(end_pulse), .ptr_mode(ptr_mode), .bus_ack(bus_ack),
  .bus_rdata(bus_rdata), .led_duty(led_duty), .grp_rate(grp_rate),
  .sleep(sleep), .out_totem(out_totem), .wake_pending(wake_pending)
);

// File: tb/mode_reg_bank_tb.sv
module mode_reg_bank_tb;
  localparam int WK = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd, end_pulse;
  logic [2:0]  ptr_mode;
  logic        bus_ack;
  logic [7:0]  bus_rdata;
  logic [31:0] led_duty;
  logic [7:0]  grp_duty, grp_rate, led_state, bcast_addr;
  logic [23:0] sub_addr;
  logic        sleep, bcast_en, grp_blink, out_invert, upd_on_ack, out_totem;
  logic [2:0]  sub_en;
  logic [1:0]  out_idle;
  logic        wake_pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mode_reg_bank #(.WAKE_CYCLES(WK)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .end_pulse(end_pulse), .ptr_mode(ptr_mode),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .led_duty(led_duty),
    .grp_duty(grp_duty), .grp_rate(grp_rate), .led_state(led_state),
    .sub_addr(sub_addr), .bcast_addr(bcast_addr), .sleep(sleep), .sub_en(sub_en),
    .bcast_en(bcast_en), .grp_blink(grp_blink), .out_invert(out_invert),
    .upd_on_ack(upd_on_ack), .out_totem(out_totem), .out_idle(out_idle),
    .wake_pending(wake_pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 0; bus_rd = 0; end_pulse = 0;
    bus_addr = 0; bus_wdata = 0; ptr_mode = 3'b100;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic exp_ack, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(tag, {31'd0, bus_ack}, {31'd0, exp_ack});
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input logic exp_ack, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, {31'd0, bus_ack}, {31'd0, exp_ack});
    chk(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic pulse_end();
    end_pulse = 1'b1;
    @(negedge clk);
    end_pulse = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sleep", {31'd0, sleep}, 1);
    chk("R1 bcast_en", {31'd0, bcast_en}, 1);
    chk("R1 sub_en", {29'd0, sub_en}, 0);
    chk("R1 mode1 bits", {26'd0, grp_blink, out_invert, upd_on_ack, out_totem, out_idle}, 32'h04);
    chk("R1 duty", led_duty, 0);
    chk("R1 addrs", {sub_addr, bcast_addr}, 0);
    chk("R1 wake", {31'd0, wake_pending}, 0);
    rd(4'h0, 8'h91, 1, "R1 R4 read idx0");
    rd(4'h1, 8'h04, 1, "R1 read idx1");
  endtask

  task automatic t_mirror();
    do_reset();
    ptr_mode = 3'b111;
    rd(4'h0, 8'hF1, 1, "R2 mirror 111");
    wr(4'h0, 8'h05, 1, "R2 write ack");
    rd(4'h0, 8'hE5, 1, "R2 write ignored hi bits");
    ptr_mode = 3'b101;
    wr(4'h0, 8'hFF, 1, "R2 write ones");
    rd(4'h0, 8'hBF, 1, "R2 mirror 101");
  endtask

  task automatic t_reserved();
    do_reset();
    wr(4'h1, 8'hC0, 1, "R3 write");
    rd(4'h1, 8'h00, 1, "R3 read zero");
    wr(4'h1, 8'hFF, 1, "R3 write ones");
    rd(4'h1, 8'h3F, 1, "R3 read masked");
  endtask

  task automatic t_range();
    do_reset();
    rd(4'h2, 8'h00, 1, "R5 prior read");
    wr(4'hD, 8'hFF, 0, "R5 write 0xD no ack");
    wr(4'hF, 8'hAA, 0, "R5 write 0xF no ack");
    rd(4'hE, 8'h00, 0, "R5 read 0xE");
    pulse_end();
    chk("R5 outputs", {led_duty[7:0], grp_duty, bcast_addr, 7'd0, sleep}, 32'h1);
    rd(4'h0, 8'h91, 1, "R5 idx0 unchanged");
    rd(4'hC, 8'h00, 1, "R5 R4 idx C ack");
  endtask

  task automatic t_defer();
    do_reset();
    wr(4'h2, 8'h5A, 1, "R6 write duty0");
    wr(4'h0, 8'h01, 1, "R6 write sleep0");
    chk("R6 duty held", led_duty, 0);
    chk("R6 sleep held", {31'd0, sleep}, 1);
    rd(4'h2, 8'h5A, 1, "R6 shadow readback");
    pulse_end();
    chk("R6 duty copied", led_duty, 32'h5A);
    chk("R6 sleep copied", {31'd0, sleep}, 0);
  endtask

  task automatic t_ack_mode();
    do_reset();
    wr(4'h1, 8'h0C, 1, "R10 set timing");
    chk("R10 timing write deferred", {31'd0, upd_on_ack}, 0);
    wr(4'h3, 8'h33, 1, "R7 write duty1");
    chk("R7 R10 immediate", led_duty, 32'h3300);
    pulse_end();
    chk("R10 timing active", {31'd0, upd_on_ack}, 1);
    wr(4'h7, 8'h42, 1, "R7 write rate");
    chk("R7 rate immediate", {24'd0, grp_rate}, 32'h42);
  endtask

  task automatic t_end_with_write();
    do_reset();
    bus_addr = 4'h7; bus_wdata = 8'h77; bus_wr = 1'b1; end_pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; end_pulse = 1'b0;
    chk("R11 same-cycle write", {24'd0, grp_rate}, 32'h77);
  endtask

  task automatic t_map();
    do_reset();
    for (int i = 2; i <= 12; i++) wr(4'(i), 8'(i * 8'h11), 1, "R8 fill");
    wr(4'h0, 8'h0E, 1, "R8 mode0");
    wr(4'h1, 8'h33, 1, "R8 mode1");
    pulse_end();
    chk("R8 led_duty", led_duty, 32'h55443322);
    chk("R8 group", {16'd0, grp_duty, grp_rate}, 32'h6677);
    chk("R8 state", {24'd0, led_state}, 32'h88);
    chk("R8 sub_addr", {8'd0, sub_addr}, 32'hBBAA99);
    chk("R8 bcast_addr", {24'd0, bcast_addr}, 32'hCC);
    chk("R8 mode0 map", {27'd0, sleep, sub_en, bcast_en}, 32'b01110);
    chk("R8 mode1 map", {26'd0, grp_blink, out_invert, upd_on_ack, out_totem, out_idle}, 32'b110011);
  endtask

  task automatic t_wake();
    do_reset();
    wr(4'h1, 8'h0C, 1, "R9 timing");
    pulse_end();
    wr(4'h0, 8'h01, 1, "R9 release sleep");
    chk("R9 sleep low", {31'd0, sleep}, 0);
    chk("R9 pending start", {31'd0, wake_pending}, 1);
    repeat (WK - 1) @(negedge clk);
    chk("R9 pending last", {31'd0, wake_pending}, 1);
    @(negedge clk);
    chk("R9 pending end", {31'd0, wake_pending}, 0);
    wr(4'h0, 8'h11, 1, "R9 sleep again");
    wr(4'h0, 8'h01, 1, "R9 release again");
    wr(4'h0, 8'h11, 1, "R9 set during window");
    chk("R9 cleared by sleep", {31'd0, wake_pending}, 0);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; end_pulse = 0;
    bus_addr = 0; bus_wdata = 0; ptr_mode = 3'b100;
    t_reset();
    t_mirror();
    t_reserved();
    t_range();
    t_defer();
    t_ack_mode();
    t_end_with_write();
    t_map();
    t_wake();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule